// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address after a TLB miss. It walks a two-level table held in memory and returns the physical address, the 2-bit access mode that governed the access, and a fault indication. A walk reads one descriptor, or two, through a request/response memory port. Only one walk is in flight at a time.

A first-level entry can map a 1 MB section directly. It can also point to a 1 KB-aligned second-level table whose entries map 4 KB pages. The location of the top-level table comes from the table base input. The requester supplies the access kind (read or write) and the privilege level. The walker checks these against the mode bits of the final descriptor.

Descriptor layout, used at both levels: bits [1:0] hold the type code and bits [3:2] hold the access mode. At the first level, type 2'b10 is a section, with the frame in [31:20]. Type 2'b01 is a table pointer, with the table base in [31:10]. A second-level entry of type 2'b00 is a page, with the frame in [31:12].

Top module: `pt_walker`

## Requirements
- R1: The first descriptor read goes to `tbl_base_i + {va[31:20], 2'b00}`, where `va` is the value of `req_va_i` when the walk is accepted.
- R2: A first-level type 2'b10 completes after exactly one read, with `pa_o = {desc[31:20], va[19:0]}` and `am_o = desc[3:2]`.
- R3: A first-level type 2'b01 starts a second read at `{desc[31:10], va[19:12], 2'b00}`. A second-level type 2'b00 then completes with `pa_o = {desc2[31:12], va[11:0]}`, after exactly two reads.
- R4: A first-level type of 2'b00 or 2'b11 ends the walk after one read with a translation fault: `fault_o=1`, `fault_perm_o=0`, `pa_o=0` and `am_o=0`.
- R5: A second-level type other than 2'b00 ends the walk with the same translation fault.
- R6: Access modes are checked as follows. 2'b00 denies every access. 2'b01 allows reads only. 2'b10 allows reads and writes for privileged requests only. 2'b11 allows everything. A denied access gives `fault_o=1`, `fault_perm_o=1`, `pa_o=0`, with `am_o` showing the mode that was checked.
- R7: For a page mapping, only the second-level mode is checked. The mode bits of the first-level pointer have no effect.
- R8: `busy_o` is high from the cycle after a request is accepted until the done cycle. `done_o` is a single-cycle pulse, and busy is low during it. A `req_valid_i` seen while busy is ignored.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` is sampled. The walk accepts any response latency, including a response in the same cycle as the request.
- R10: After reset, `busy_o`, `done_o`, `mem_req_o`, `fault_o` and `pa_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken only when idle) |
| req_va_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_priv_i | input | 1 | 1 = privileged requester |
| tbl_base_i | input | 32 | Physical base of the top-level table |
| mem_req_o | output | 1 | Descriptor read pending |
| mem_addr_o | output | 32 | Descriptor address |
| mem_rvalid_i | input | 1 | Descriptor data valid |
| mem_rdata_i | input | 32 | Descriptor data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Physical address (zero on fault) |
| am_o | output | 2 | Access mode that was checked |
| fault_o | output | 1 | Walk ended in a fault |
| fault_perm_o | output | 1 | 1 = permission fault, 0 = translation fault |

## Verification
A wrong walk state shows up on `mem_addr_o` or `mem_req_o` in the first cycle after the faulty transition. For example, a section that is wrongly taken as a table pointer issues an extra read, one cycle after the first response. The bench's cycle model compares busy, request, address and done on every clock, so such a divergence is reported in the cycle it appears. Errors in address forming or mode checking appear only in the done cycle, where pa, mode and fault fields are compared against hand-derived values for each descriptor kind and mode.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_BAD     = 2'd0,
    DK_SECTION = 2'd1,
    DK_TABLE   = 2'd2,
    DK_PAGE    = 2'd3
  } desc_kind_e;

  localparam logic [1:0] TY_SECTION = 2'b10;
  localparam logic [1:0] TY_TABLE   = 2'b01;
  localparam logic [1:0] TY_PAGE    = 2'b00;

  localparam logic [1:0] AM_NONE    = 2'b00;
  localparam logic [1:0] AM_RO      = 2'b01;
  localparam logic [1:0] AM_PRIV_RW = 2'b10;
  localparam logic [1:0] AM_ALL_RW  = 2'b11;
endpackage

// File: rtl/pt_desc_decode.sv
module pt_desc_decode
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int L2_IDX_W   = 8,
  parameter int PAGE_OFF_W = 12
) (
  input  logic [ADDR_W-1:0]                desc_i,
  input  logic                             level2_i,
  input  logic [L2_IDX_W+PAGE_OFF_W-1:0]   va_low_i,
  output desc_kind_e                       kind_o,
  output logic [1:0]                       am_o,
  output logic [ADDR_W-1:0]                pa_o,
  output logic [ADDR_W-1:0]                next_addr_o
);
  localparam int SECT_OFF_W = L2_IDX_W + PAGE_OFF_W;
  localparam int TBL_ALIGN  = L2_IDX_W + 2;

  logic [1:0] ty;
  logic [5:0] unused_bits;

  assign ty          = desc_i[1:0];
  assign am_o        = desc_i[3:2];
  assign unused_bits = desc_i[9:4];

  always_comb begin
    kind_o = DK_BAD;
    if (level2_i) begin
      if (ty == TY_PAGE) kind_o = DK_PAGE;
    end else begin
      unique case (ty)
        TY_SECTION: kind_o = DK_SECTION;
        TY_TABLE:   kind_o = DK_TABLE;
        default:    kind_o = DK_BAD;
      endcase
    end
  end

  // section keeps VA[19:0], page keeps VA[11:0]
  assign pa_o = level2_i ? {desc_i[ADDR_W-1:PAGE_OFF_W], va_low_i[PAGE_OFF_W-1:0]}
                         : {desc_i[ADDR_W-1:SECT_OFF_W], va_low_i};

  // table is 1 KB aligned, so the index concatenates
  assign next_addr_o = {desc_i[ADDR_W-1:TBL_ALIGN], va_low_i[SECT_OFF_W-1:PAGE_OFF_W], 2'b00};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
(
  input  logic [1:0] am_i,
  input  logic       write_i,
  input  logic       priv_i,
  output logic       ok_o
);
  always_comb begin
    unique case (am_i)
      AM_NONE:    ok_o = 1'b0;
      AM_RO:      ok_o = !write_i;
      AM_PRIV_RW: ok_o = priv_i;
      AM_ALL_RW:  ok_o = 1'b1;
      default:    ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int L2_IDX_W   = 8,
  parameter int PAGE_OFF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic              req_write_i,
  input  logic              req_priv_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [1:0]        am_o,
  output logic              fault_o,
  output logic              fault_perm_o
);
  localparam int SECT_OFF_W = L2_IDX_W + PAGE_OFF_W;
  localparam int L1_IDX_W   = ADDR_W - SECT_OFF_W;
  localparam int L1_PAD_W   = ADDR_W - L1_IDX_W - 2;

  walk_state_e             state_q;
  logic [SECT_OFF_W-1:0]   va_q;
  logic                    wr_q, priv_q;
  logic [ADDR_W-1:0]       addr_q;
  logic                    done_q, fault_q, perm_q;
  logic [ADDR_W-1:0]       pa_q;
  logic [1:0]              am_q;

  desc_kind_e        kind;
  logic [1:0]        dec_am;
  logic [ADDR_W-1:0] dec_pa, dec_next;
  logic              perm_ok;
  logic [ADDR_W-1:0] l1_addr;

  assign l1_addr = tbl_base_i + {{L1_PAD_W{1'b0}}, req_va_i[ADDR_W-1:SECT_OFF_W], 2'b00};

  pt_desc_decode #(
    .ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W), .PAGE_OFF_W(PAGE_OFF_W)
  ) u_dec (
    .desc_i      (mem_rdata_i),
    .level2_i    (state_q == ST_L2),
    .va_low_i    (va_q),
    .kind_o      (kind),
    .am_o        (dec_am),
    .pa_o        (dec_pa),
    .next_addr_o (dec_next)
  );

  pt_perm_check u_perm (
    .am_i    (dec_am),
    .write_i (wr_q),
    .priv_i  (priv_q),
    .ok_o    (perm_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      priv_q  <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      perm_q  <= 1'b0;
      pa_q    <= '0;
      am_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_va_i[SECT_OFF_W-1:0];
            wr_q    <= req_write_i;
            priv_q  <= req_priv_i;
            addr_q  <= l1_addr;
            state_q <= ST_L1;
          end
        end
        ST_L1, ST_L2: begin
          if (mem_rvalid_i) begin
            if (kind == DK_TABLE) begin
              addr_q  <= dec_next;
              state_q <= ST_L2;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              if (kind == DK_BAD) begin
                fault_q <= 1'b1;
                perm_q  <= 1'b0;
                pa_q    <= '0;
                am_q    <= '0;
              end else begin
                fault_q <= !perm_ok;
                perm_q  <= !perm_ok;
                pa_q    <= perm_ok ? dec_pa : '0;
                am_q    <= dec_am;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign mem_req_o    = busy_o;
  assign mem_addr_o   = addr_q;
  assign done_o       = done_q;
  assign pa_o         = pa_q;
  assign am_o         = am_q;
  assign fault_o      = fault_q;
  assign fault_perm_o = perm_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] pa_o,
  input logic [1:0]        am_o,
  input logic              fault_o,
  input logic              fault_perm_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  // R9
  req_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R4
  xlat_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o && !fault_perm_o |-> pa_o == '0 && am_o == 2'b00);

  // R6
  perm_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_perm_o |-> fault_o && pa_o == '0);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pa_o         (pa_o),
  .am_o         (am_o),
  .fault_o      (fault_o),
  .fault_perm_o (fault_perm_o)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_priv_i = 1'b0;
  logic [31:0] tbl_base_i = 32'h0004_0000;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o, fault_o, fault_perm_o;
  logic [31:0] pa_o;
  logic [1:0]  am_o;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wait_cnt = 0;
  int rd_cnt = 0;
  logic [31:0] mem_m [logic [31:0]];

  always #2.5 clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_va_i(req_va_i),
    .req_write_i(req_write_i), .req_priv_i(req_priv_i), .tbl_base_i(tbl_base_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .pa_o(pa_o),
    .am_o(am_o), .fault_o(fault_o), .fault_perm_o(fault_perm_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  // memory responder with programmable latency
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_rvalid_i = 1'b0;
      wait_cnt = 0;
    end else if (mem_rvalid_i) begin
      mem_rvalid_i = 1'b0;
      wait_cnt = 0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i = rd_mem(mem_addr_o);
        rd_cnt++;
      end else begin
        wait_cnt++;
      end
    end
  end

  // behavioural reference
  int          m_ph = 0;
  logic [31:0] m_va, m_addr, m_pa;
  logic        m_wr, m_pr, m_done, m_fault, m_perm;
  logic [1:0]  m_am;

  function automatic bit allowed(input logic [1:0] am, input logic wr, input logic pr);
    return (am == 2'd3) || (am == 2'd2 && pr) || (am == 2'd1 && !wr);
  endfunction

  task automatic m_finish(input bit bad, input logic [31:0] pa, input logic [1:0] am);
    m_ph = 0;
    m_done = 1'b1;
    if (bad) begin
      m_fault = 1'b1; m_perm = 1'b0; m_pa = 0; m_am = 0;
    end else if (allowed(am, m_wr, m_pr)) begin
      m_fault = 1'b0; m_perm = 1'b0; m_pa = pa; m_am = am;
    end else begin
      m_fault = 1'b1; m_perm = 1'b1; m_pa = 0; m_am = am;
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_addr = 0; m_pa = 0; m_am = 0; m_done = 0; m_fault = 0; m_perm = 0;
      m_va = 0; m_wr = 0; m_pr = 0;
    end else begin
      logic [31:0] d;
      d = mem_rdata_i;
      m_done = 1'b0;
      if (m_ph == 0) begin
        if (req_valid_i) begin
          m_va = req_va_i; m_wr = req_write_i; m_pr = req_priv_i;
          m_addr = tbl_base_i + (req_va_i >> 20) * 4;
          m_ph = 1;
        end
      end else if (mem_rvalid_i) begin
        if (m_ph == 1) begin
          if (d[1:0] == 2'b10) m_finish(0, (d & 32'hFFF0_0000) | (m_va & 32'h000F_FFFF), d[3:2]);
          else if (d[1:0] == 2'b01) begin
            m_addr = (d & 32'hFFFF_FC00) + ((m_va >> 12) & 32'hFF) * 4;
            m_ph = 2;
          end else m_finish(1, 0, 0);
        end else begin
          if (d[1:0] != 2'b00) m_finish(1, 0, 0);
          else m_finish(0, (d & 32'hFFFF_F000) | (m_va & 32'hFFF), d[3:2]);
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(busy_o == (m_ph != 0), "R8 busy", busy_o, m_ph != 0);
      check(mem_req_o == (m_ph != 0), "R9 mem_req", mem_req_o, m_ph != 0);
      check(done_o == m_done, "R8 done", done_o, m_done);
      if (m_ph != 0) check(mem_addr_o == m_addr, m_ph == 1 ? "R1 l1 addr" : "R3 l2 addr", mem_addr_o, m_addr);
      if (m_done) begin
        check(pa_o == m_pa, "R2 R3 pa", pa_o, m_pa);
        check(am_o == m_am, "R6 am", am_o, m_am);
        check({fault_o, fault_perm_o} == {m_fault, m_perm}, "R4 R5 R6 fault", {fault_o, fault_perm_o}, {m_fault, m_perm});
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit pr, input bit ef, input bit ep,
                      input logic [31:0] epa, input logic [1:0] eam, input int erd, input int hold,
                      input string tag);
    int n;
    @(negedge clk_i);
    rd_cnt = 0;
    req_valid_i = 1'b1; req_va_i = va; req_write_i = wr; req_priv_i = pr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      req_va_i = va ^ 32'hFFF0_0000;
      req_write_i = !wr;
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check(done_o, {tag, " done"}, done_o, 1);
    check(fault_o == ef, {tag, " fault"}, fault_o, ef);
    if (ef) check(fault_perm_o == ep, {tag, " kind"}, fault_perm_o, ep);
    check(pa_o == epa, {tag, " pa"}, pa_o, epa);
    check(am_o == eam, {tag, " am"}, am_o, eam);
    check(rd_cnt == erd, {tag, " reads"}, rd_cnt, erd);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mem_m[32'h0004_1008] = 32'h5000_000E;  // section, mode 11
    mem_m[32'h0004_100C] = 32'h6000_0006;  // section, mode 01
    mem_m[32'h0004_1010] = 32'h7000_000A;  // section, mode 10
    mem_m[32'h0004_1014] = 32'h8000_0002;  // section, mode 00
    mem_m[32'h0004_1018] = 32'h0008_0401;  // table at 0x80400, mode 00
    mem_m[32'h0004_101C] = 32'h9000_000F;  // type 11
    mem_m[32'h0008_06AC] = 32'h1234_500C;  // page, mode 11
    mem_m[32'h0008_06B0] = 32'h2222_2004;  // page, mode 01
    mem_m[32'h0008_06B4] = 32'h3333_300A;  // L2 type 10

    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(!busy_o && !done_o && !mem_req_o, "R10 ctrl", {busy_o, done_o, mem_req_o}, 0);
    check(pa_o == 0 && !fault_o, "R10 result", pa_o, 0);
    rst_ni = 1'b1;

    lat = 0;
    walk(32'h4027_7123, 0, 0, 0, 0, 32'h5007_7123, 2'd3, 1, 0, "R2 section");
    walk(32'h4031_2345, 0, 0, 0, 0, 32'h6001_2345, 2'd1, 1, 0, "R6 ro read");
    walk(32'h4031_2345, 1, 1, 1, 1, 32'h0,         2'd1, 1, 0, "R6 ro write");
    lat = 3;
    walk(32'h4040_0010, 0, 0, 1, 1, 32'h0,         2'd2, 1, 0, "R6 priv-only user");
    walk(32'h4040_0010, 1, 1, 0, 0, 32'h7000_0010, 2'd2, 1, 0, "R6 priv-only priv");
    walk(32'h4050_0000, 0, 1, 1, 1, 32'h0,         2'd0, 1, 0, "R6 no access");
    walk(32'h406A_B123, 0, 0, 0, 0, 32'h1234_5123, 2'd3, 2, 0, "R3 R7 page");
    lat = 1;
    walk(32'h406A_C000, 1, 1, 1, 1, 32'h0,         2'd1, 2, 0, "R7 page ro write");
    walk(32'h406A_C7FF, 0, 0, 0, 0, 32'h2222_27FF, 2'd1, 2, 0, "R7 page ro read");
    walk(32'h406A_D000, 0, 1, 1, 0, 32'h0,         2'd0, 2, 0, "R5 l2 bad type");
    walk(32'h4070_0000, 0, 1, 1, 0, 32'h0,         2'd0, 1, 0, "R4 type 11");
    walk(32'h4080_0000, 0, 1, 1, 0, 32'h0,         2'd0, 1, 0, "R4 type 00");
    lat = 3;
    walk(32'h4027_7ABC, 0, 0, 0, 0, 32'h5007_7ABC, 2'd3, 1, 2, "R8 ignore while busy");
    lat = 4;
    walk(32'h406A_B001, 0, 0, 0, 0, 32'h1234_5001, 2'd3, 2, 3, "R9 long latency");

    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o, "R8 idle after", {busy_o, done_o}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule